// File: doc/BRIEF.md
# IR Carrier Frequency Detector

This block watches a raw, still-modulated infrared receiver line and measures the carrier riding on it. Each carrier cycle is timed from one rising edge to the next. The block also times how long the line stays high inside that cycle. Both times are counted in units of 500 ns, taken from a prescaled tick. At the start of every burst, a programmable number of carrier cycles is skipped so that the receiver front end can settle. A programmable number of the cycles that follow is then averaged. The two averages are published in two byte-wide result registers.

A single configuration byte sets the behaviour. Its upper nibble is the number of leading cycles to skip. Its lower nibble is the number of cycles to average. The most significant bit of the period result is a fresh-result flag. A one-cycle read strobe on the period register clears that flag. Measurement runs only while the detect enable is high. A silence longer than 127 units is taken as the end of a burst.

Top module: `ir_carrier_meter`

## Requirements
- R1: While reset is held and just after its release, both result registers read 0x00.
- R2: The period result bits [6:0] hold the floor of the sum of the averaged carrier periods divided by the averaging count. Each period is measured in 500 ns units, from a rising edge to the next rising edge.
- R3: The high-time result bits [6:0] hold the floor of the averaged high times over the same cycles. Bit 7 of the high-time result is always 0.
- R4: The first D measured periods of a burst are skipped and take no part in the average, where D is configuration bits [7:4].
- R5: The averaging count N is configuration bits [3:0]. A value of 0 acts as 1.
- R6: Period result bit 7 goes to 1 in the cycle a new average is stored. A one-cycle read strobe clears it and leaves bits [6:0] as they were. A new average arriving in the same cycle as the strobe wins.
- R7: If no rising edge arrives for more than 127 units, the burst ends. The partial sums and the skip count are dropped. The next rising edge only starts a new measurement and contributes no period.
- R8: While the detect enable is low, no result changes and bit 7 is never set. Lowering the enable drops any partial burst.
- R9: Within one burst, once an average has been stored, every further N periods produce another average, with no new skip phase.
- R10: The first rising edge of a burst only arms the timer. A burst of K rising edges yields K-1 periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_raw | input | 1 | Raw modulated receiver line, asynchronous |
| det_en | input | 1 | Carrier detection enable |
| det_cfg | input | 8 | [7:4] cycles to skip, [3:0] cycles to average |
| per_rd | input | 1 | One-cycle read strobe of the period result |
| per_res | output | 8 | [7] fresh flag, [6:0] average period in 500 ns units |
| hi_res | output | 8 | [7] zero, [6:0] average high time in 500 ns units |

## Verification
The hardest case to reach from the ports is a partial average that must be thrown away. This happens when a burst stops after some periods have been summed but before N is reached. The same drop must happen when the enable falls in the middle of a burst. The bench drives such a burst with long periods. It then either holds the line low past the 127-unit limit, or pulses the enable low while the line is idle. After that it sends a burst with short periods. Any leftover sum, and any spurious period taken from the silent stretch, would move the reported average far away from the short period.

// File: rtl/ir_carr_pkg.sv
package ir_carr_pkg;
  localparam int RES_W     = 7;
  localparam int NIB_W     = 4;
  localparam int CNT_W     = RES_W + 1;
  localparam int SUM_W     = RES_W + NIB_W;
  localparam int GAP_UNITS = 1 << RES_W;

  typedef struct packed {
    logic [RES_W-1:0] per;
    logic [RES_W-1:0] hi;
  } carr_sample_t;
endpackage

// File: rtl/ir_carr_rst_sync.sv
module ir_carr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ir_carr_front.sv
module ir_carr_front #(
  parameter int SYNC_STAGES   = 2,
  parameter int CLKS_PER_UNIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ir_raw,
  output logic level,
  output logic rise,
  output logic tick
);
  localparam int PRE_W = (CLKS_PER_UNIT > 1) ? $clog2(CLKS_PER_UNIT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_UNIT - 1);

  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;
  logic [PRE_W-1:0]     pre_q;
  logic [PRE_W-1:0]     pre_d;
  logic                 pre_wrap;

  always_comb begin
    sh_d = {sh_q[SYNC_STAGES-1:0], ir_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign level = sh_q[SYNC_STAGES-1];
  assign rise  = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  generate
    if (CLKS_PER_UNIT > 1) begin : g_prescale
      always_comb begin
        pre_wrap = (pre_q == PRE_LAST);
        pre_d    = pre_wrap ? '0 : pre_q + 1'b1;
      end
    end else begin : g_noprescale
      always_comb begin
        pre_wrap = 1'b1;
        pre_d    = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  assign tick = pre_wrap;
endmodule

// File: rtl/ir_carr_meas.sv
module ir_carr_meas
  import ir_carr_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         level,
  input  logic         rise,
  input  logic         tick,
  output logic         smp_vld,
  output carr_sample_t smp,
  output logic         gap
);
  localparam logic [CNT_W-1:0] GAP_CNT = CNT_W'(GAP_UNITS);

  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic             armed_q, armed_d;
  logic             vld_q, vld_d;
  logic             gap_q, gap_d;
  carr_sample_t     smp_q, smp_d;
  logic             per_sat;

  always_comb begin
    per_sat = (per_q == GAP_CNT);
    per_d   = per_q;
    hi_d    = hi_q;
    armed_d = armed_q;
    vld_d   = 1'b0;
    gap_d   = 1'b0;
    smp_d   = smp_q;
    if (!en) begin
      per_d   = '0;
      hi_d    = '0;
      armed_d = 1'b0;
    end else if (rise) begin
      if (armed_q && !per_sat) begin
        vld_d     = 1'b1;
        smp_d.per = per_q[RES_W-1:0];
        smp_d.hi  = hi_q[RES_W-1:0];
      end else if (armed_q) begin
        gap_d = 1'b1;
      end
      armed_d = 1'b1;
      per_d   = {{(CNT_W-1){1'b0}}, tick};
      hi_d    = {{(CNT_W-1){1'b0}}, tick};
    end else begin
      if (tick && !per_sat) begin
        per_d = per_q + 1'b1;
      end
      if (tick && level && (hi_q != GAP_CNT)) begin
        hi_d = hi_q + 1'b1;
      end
      if (armed_q && per_sat) begin
        armed_d = 1'b0;
        gap_d   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q   <= '0;
      hi_q    <= '0;
      armed_q <= 1'b0;
      vld_q   <= 1'b0;
      gap_q   <= 1'b0;
      smp_q   <= '0;
    end else begin
      per_q   <= per_d;
      hi_q    <= hi_d;
      armed_q <= armed_d;
      vld_q   <= vld_d;
      gap_q   <= gap_d;
      if (vld_d) begin
        smp_q <= smp_d;
      end
    end
  end

  assign smp_vld = vld_q;
  assign smp     = smp_q;
  assign gap     = gap_q;

  // R3: a high time can never exceed the cycle that contains it
  a_r3_high_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (smp_q.hi <= smp_q.per));

  // R8: no period leaves the timer while detection is off
  a_r8_off_no_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld_q);
endmodule

// File: rtl/ir_carr_ctrl.sv
module ir_carr_ctrl
  import ir_carr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2*NIB_W-1:0] cfg,
  input  logic             smp_vld,
  input  logic             gap,
  input  logic             rd,
  output logic             acc_clr,
  output logic             acc_add,
  output logic             acc_fin,
  output logic [NIB_W-1:0] n_eff,
  output logic             valid
);
  logic [NIB_W-1:0] skip_lim;
  logic [NIB_W-1:0] skip_q, skip_d;
  logic [NIB_W-1:0] cnt_q, cnt_d;
  logic             valid_q, valid_d;

  always_comb begin
    skip_lim = cfg[2*NIB_W-1:NIB_W];
    n_eff    = (cfg[NIB_W-1:0] == '0) ? NIB_W'(1) : cfg[NIB_W-1:0];
    skip_d   = skip_q;
    cnt_d    = cnt_q;
    acc_clr  = 1'b0;
    acc_add  = 1'b0;
    acc_fin  = 1'b0;
    if (!en || gap) begin
      skip_d  = '0;
      cnt_d   = '0;
      acc_clr = 1'b1;
    end else if (smp_vld) begin
      if (skip_q < skip_lim) begin
        skip_d = skip_q + 1'b1;
      end else if (cnt_q >= (n_eff - 1'b1)) begin
        acc_fin = 1'b1;
        cnt_d   = '0;
      end else begin
        acc_add = 1'b1;
        cnt_d   = cnt_q + 1'b1;
      end
    end
    if (acc_fin) begin
      valid_d = 1'b1;
    end else if (rd) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q  <= '0;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      skip_q  <= skip_d;
      cnt_q   <= cnt_d;
      valid_q <= valid_d;
    end
  end

  assign valid = valid_q;

  // R6: a read strobe with no new average clears the flag
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !acc_fin) |=> !valid_q);

  // R6: a stored average always raises the flag, even against a read
  a_r6_fin_sets: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fin |=> valid_q);
endmodule

// File: rtl/ir_carr_accum.sv
module ir_carr_accum
  import ir_carr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add,
  input  logic             fin,
  input  logic [NIB_W-1:0] n,
  input  logic [RES_W-1:0] sample,
  output logic [RES_W-1:0] res
);
  localparam logic [SUM_W-1:0] RES_MAX = SUM_W'((1 << RES_W) - 1);

  logic [SUM_W-1:0] sum_q, sum_d;
  logic [SUM_W-1:0] sum_full;
  logic [SUM_W-1:0] quo;
  logic [RES_W-1:0] res_q, res_d;

  always_comb begin
    sum_full = sum_q + SUM_W'(sample);
    quo      = sum_full / {{(SUM_W-NIB_W){1'b0}}, n};
    sum_d    = sum_q;
    res_d    = res_q;
    if (clr) begin
      sum_d = '0;
    end else if (fin) begin
      sum_d = '0;
      res_d = (quo > RES_MAX) ? RES_MAX[RES_W-1:0] : quo[RES_W-1:0];
    end else if (add) begin
      sum_d = sum_full;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      res_q <= '0;
    end else begin
      if (clr || fin || add) begin
        sum_q <= sum_d;
      end
      if (fin) begin
        res_q <= res_d;
      end
    end
  end

  assign res = res_q;

  // R5: averaging a single cycle reports that cycle unchanged
  a_r5_single_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !clr && (n == NIB_W'(1)) && (sum_q == '0)) |=> (res_q == $past(sample)));
endmodule

// File: rtl/ir_carrier_meter.sv
module ir_carrier_meter
  import ir_carr_pkg::*;
#(
  parameter int CLKS_PER_UNIT = 125,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ir_raw,
  input  logic       det_en,
  input  logic [7:0] det_cfg,
  input  logic       per_rd,
  output logic [7:0] per_res,
  output logic [7:0] hi_res
);
  localparam int NCH = 2;

  logic             rst_sync_n;
  logic             level, rise, tick;
  logic             smp_vld, gap;
  carr_sample_t     smp;
  logic             acc_clr, acc_add, acc_fin, valid;
  logic [NIB_W-1:0] n_eff;
  logic [RES_W-1:0] ch_res [NCH];

  ir_carr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ir_carr_front #(.SYNC_STAGES(SYNC_STAGES), .CLKS_PER_UNIT(CLKS_PER_UNIT)) u_front (
    .clk(clk), .rst_n(rst_sync_n), .ir_raw(ir_raw),
    .level(level), .rise(rise), .tick(tick)
  );

  ir_carr_meas u_meas (
    .clk(clk), .rst_n(rst_sync_n), .en(det_en), .level(level), .rise(rise),
    .tick(tick), .smp_vld(smp_vld), .smp(smp), .gap(gap)
  );

  ir_carr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .en(det_en), .cfg(det_cfg),
    .smp_vld(smp_vld), .gap(gap), .rd(per_rd),
    .acc_clr(acc_clr), .acc_add(acc_add), .acc_fin(acc_fin),
    .n_eff(n_eff), .valid(valid)
  );

  generate
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic [RES_W-1:0] ch_sample;
      assign ch_sample = (ch == 0) ? smp.per : smp.hi;
      ir_carr_accum u_acc (
        .clk(clk), .rst_n(rst_sync_n), .clr(acc_clr), .add(acc_add),
        .fin(acc_fin), .n(n_eff), .sample(ch_sample), .res(ch_res[ch])
      );
    end
  endgenerate

  assign per_res = {valid, ch_res[0]};
  assign hi_res  = {1'b0, ch_res[1]};
endmodule

// File: tb/ir_carrier_meter_tb_top.sv
`timescale 1ns/1ps
module ir_carrier_meter_tb_top;
  localparam int U = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ir_raw;
  logic       det_en;
  logic [7:0] det_cfg;
  logic       per_rd;
  logic [7:0] per_res;
  logic [7:0] hi_res;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ir_carrier_meter #(.CLKS_PER_UNIT(U)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_raw(ir_raw), .det_en(det_en),
    .det_cfg(det_cfg), .per_rd(per_rd), .per_res(per_res), .hi_res(hi_res)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int per, input int hi);
    @(negedge clk) ir_raw = 1'b1;
    repeat (hi * U - 1) @(negedge clk);
    @(negedge clk) ir_raw = 1'b0;
    repeat ((per - hi) * U - 1) @(negedge clk);
  endtask

  task automatic close_burst();
    @(negedge clk) ir_raw = 1'b1;
    repeat (U) @(negedge clk);
    ir_raw = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic idle_gap();
    @(negedge clk) ir_raw = 1'b0;
    repeat (140 * U) @(negedge clk);
  endtask

  task automatic read_per();
    @(negedge clk) per_rd = 1'b1;
    @(negedge clk) per_rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 period after reset", per_res, 8'h00);
    chk("R1 high after reset", hi_res, 8'h00);
  endtask

  task automatic t_average();
    det_cfg = 8'h04;
    idle_gap();
    pulse(12, 3); pulse(13, 4); pulse(14, 5); pulse(16, 6);
    close_burst();
    chk("R2 R10 average period", per_res, 8'h80 | 13);
    chk("R3 average high", hi_res, 4);
  endtask

  task automatic t_read();
    read_per();
    @(negedge clk);
    chk("R6 flag cleared by read", per_res, 13);
    chk("R6 high untouched by read", hi_res, 4);
  endtask

  task automatic t_discard();
    det_cfg = 8'h22;
    idle_gap(); read_per();
    pulse(30, 5); pulse(30, 5); pulse(10, 5); pulse(10, 5);
    close_burst();
    chk("R4 skipped periods left out", per_res, 8'h80 | 10);
    chk("R4 skipped high left out", hi_res, 5);
  endtask

  task automatic t_count();
    det_cfg = 8'h00;
    idle_gap(); read_per();
    pulse(9, 2);
    close_burst();
    chk("R5 zero count acts as one", per_res, 8'h80 | 9);
    chk("R5 zero count high", hi_res, 2);
    det_cfg = 8'h03;
    idle_gap(); read_per();
    pulse(7, 2); pulse(8, 3); pulse(11, 4);
    close_burst();
    chk("R2 floor of average over three", per_res, 8'h80 | 8);
    chk("R3 average high over three", hi_res, 3);
  endtask

  task automatic t_gap();
    det_cfg = 8'h02;
    idle_gap(); read_per();
    pulse(20, 5); pulse(20, 5);
    idle_gap();
    chk("R7 no result from partial burst", per_res[7], 0);
    pulse(8, 2); pulse(8, 2);
    close_burst();
    chk("R7 partial sum dropped after gap", per_res, 8'h80 | 8);
    chk("R7 high after gap", hi_res, 2);
  endtask

  task automatic t_multi();
    det_cfg = 8'h12;
    idle_gap(); read_per();
    pulse(25, 5); pulse(10, 3); pulse(12, 5); pulse(20, 8);
    chk("R9 first average in burst", per_res, 8'h80 | 11);
    chk("R9 first high in burst", hi_res, 4);
    read_per();
    pulse(30, 10);
    close_burst();
    chk("R9 second average without skip", per_res, 8'h80 | 25);
    chk("R9 second high", hi_res, 9);
  endtask

  task automatic t_disable();
    det_cfg = 8'h00;
    idle_gap(); read_per();
    det_en = 1'b0;
    pulse(15, 4); pulse(15, 4); pulse(15, 4);
    close_burst();
    chk("R8 period held while off", per_res, 25);
    chk("R8 high held while off", hi_res, 9);
    det_en = 1'b1;
    det_cfg = 8'h03;
    idle_gap();
    pulse(30, 10); pulse(30, 10); pulse(30, 10);
    @(negedge clk) det_en = 1'b0;
    repeat (3) @(negedge clk);
    det_en = 1'b1;
    pulse(6, 2); pulse(6, 2); pulse(6, 2);
    close_burst();
    chk("R8 partial burst dropped by disable", per_res, 8'h80 | 6);
    chk("R8 high after re-enable", hi_res, 2);
  endtask

  initial begin
    rst_n   = 1'b0;
    ir_raw  = 1'b0;
    det_en  = 1'b1;
    det_cfg = 8'h00;
    per_rd  = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_average();
    t_read();
    t_discard();
    t_count();
    t_gap();
    t_multi();
    t_disable();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule